// File: doc/BRIEF.md
# Memory-Module Temperature Poll Arbiter

This block sits between the register front end of a channel's SMBus host and the bit-level bus engine. While automatic polling is enabled, it visits the temperature sensors of the populated memory slots one after another and keeps the newest 16-bit reading of each slot in its own register. No software is involved. When polling is disabled, it passes a single software-triggered transaction to the same engine. If a poll is in flight when polling is disabled, that poll is allowed to finish first.

The interval between polls is set by a rate value. A pending bus error holds polling off. Polling can run in two ways: it can write the sensor's pointer register before every read, or it can trust the pointer that is already set and only read. A thermal lock input keeps polling on whatever the configuration bit says. A soft reset drops any poll in progress.

Top module: `tsense_poll_arb`

## Requirements
- R1: After rst_n is low at a clock edge, busy and eng_req are 0, poll_en_rd is 0 when poll_en_cfg and thermal_lock are 0, last_slot is NUM_SLOTS-1 and every temperature field is 0.
- R2: poll_en_rd is the OR of poll_en_cfg and thermal_lock. With thermal_lock high, automatic polls run even when poll_en_cfg is 0.
- R3: A sw_trig pulse issues a request with eng_op = 2 (software transaction) only if busy is 0 and poll_en_rd is 0. In every other case the pulse is dropped.
- R4: Clearing poll_en_cfg during a poll does not cut it short. The remaining phases are still issued and busy stays 1 until the done of the last phase. A software trigger is accepted only after that.
- R5: While bus_err is 1, no automatic poll starts. Polling resumes once bus_err returns to 0.
- R6: Polls visit only slots whose slot_present bit is 1, in ascending order with wrap-around, starting after the value in last_slot. last_slot takes the slot number when a poll starts, so after reset the first poll goes to the lowest present slot.
- R7: With ptr_sel = 0, each poll issues a pointer write (eng_op = 1) and then a read (eng_op = 0) to the same slot. With ptr_sel = 1, it issues only the read. A pointer write that ends with eng_err ends the poll without a read.
- R8: With ptr_sel = 1 and polling enabled, the next poll request goes high rate_limit+2 clock cycles after the done pulse of the previous poll's read.
- R9: A read that ends without eng_err stores eng_rdata in the field for that slot, bits [16*s+15:16*s] of temp_all. A read that ends with eng_err leaves the field unchanged.
- R10: soft_rst returns the arbiter to idle on the next edge (busy 0, no request). The aborted poll writes no temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_en_cfg | input | 1 | Configured automatic-poll enable |
| thermal_lock | input | 1 | Forces polling on |
| ptr_sel | input | 1 | 1: pointer already valid, read only |
| slot_present | input | NUM_SLOTS | Sensor present per slot |
| rate_limit | input | RATE_W | Idle cycles before the next poll |
| bus_err | input | 1 | Pending bus error flag |
| soft_rst | input | 1 | Aborts any poll, back to idle |
| sw_trig | input | 1 | Software transaction trigger pulse |
| eng_done | input | 1 | Engine finished current phase |
| eng_err | input | 1 | Engine phase ended in error (valid with done) |
| eng_rdata | input | TEMP_W | Engine read data (valid with done) |
| eng_req | output | 1 | One-cycle request to the engine |
| eng_op | output | 2 | 0 read, 1 pointer write, 2 software |
| eng_slot | output | SLOT_W | Slot of the automatic request |
| busy | output | 1 | A transaction is in flight |
| poll_en_rd | output | 1 | Effective poll enable read-back |
| last_slot | output | SLOT_W | Slot of the most recent automatic poll |
| temp_all | output | NUM_SLOTS*TEMP_W | Latest temperature per slot |

## Verification
The round-robin is driven with five presence patterns: all slots populated, a sparse set that crosses the wrap point, a single low slot, two slots at opposite ends, and a pair that starts mid-range. The pointer mode is toggled between the patterns, so that order errors, wrap errors and a pointer phase that is missing or extra each show up as a different mismatch. Directed runs then place a disable, a software trigger, a bus error, an engine error and a soft reset at chosen points inside a poll. These runs separate "finishes the poll" from "aborts" and "drops" from "queues". A timed run checks the poll interval cycle by cycle.

// File: rtl/tsp_pkg.sv
// Shared encodings for the temperature poll arbiter.
package tsp_pkg;
    // Engine operation codes seen on eng_op.
    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PTR  = 2'd1,
        OP_SW   = 2'd2
    } tsp_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR,
        ST_READ,
        ST_SW
    } tsp_state_e;
endpackage

// File: rtl/tsp_slot_pick.sv
// Chooses the next present slot after `last` in ascending, wrapping order.
// Assumes NUM_SLOTS >= 2. Pure combinational; returns `last` when no slot is present.
module tsp_slot_pick #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [SLOT_W-1:0]    last,
    output logic [SLOT_W-1:0]    pick,
    output logic                 any
);
    logic found;

    // Scan forward from last+1 and take the first present slot.
    always_comb begin
        pick  = last;
        found = 1'b0;
        any   = |present;
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            int idx;
            idx = (int'(last) + k) % NUM_SLOTS;
            if (!found && present[idx]) begin
                found = 1'b1;
                pick  = idx[SLOT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tsp_interval.sv
// Poll interval counter: counts while `run` is high, saturating at `limit`.
// Any cycle with `run` low clears it, so it restarts after every poll.
module tsp_interval #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] limit,
    output logic              expired
);
    logic [RATE_W-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    // Count idle enabled cycles up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tsp_seq.sv
// Transaction sequencer: issues pointer-write/read phases for automatic polls
// or one software phase. Assumes the engine answers each request with exactly
// one eng_done pulse. Requests are registered and last one cycle.
module tsp_seq
    import tsp_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic              sw_go,
    input  logic              ptr_sel,
    input  logic [SLOT_W-1:0] pick,
    input  logic              done,
    input  logic              err,
    output logic              busy,
    output logic              req,
    output tsp_op_e           op,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] last,
    output logic              wr_en
);
    tsp_state_e        state_q;
    logic              req_q;
    tsp_op_e           op_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] last_q;

    assign busy  = (state_q != ST_IDLE);
    assign req   = req_q;
    assign op    = op_q;
    assign slot  = slot_q;
    assign last  = last_q;
    assign wr_en = (state_q == ST_READ) && done && !err && !soft_rst;

    // State walk and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            op_q    <= OP_READ;
            slot_q  <= '0;
            last_q  <= SLOT_W'(NUM_SLOTS - 1);
        end else begin
            req_q <= 1'b0;
            if (soft_rst) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            last_q <= pick;
                            slot_q <= pick;
                            req_q  <= 1'b1;
                            if (ptr_sel) begin
                                state_q <= ST_READ;
                                op_q    <= OP_READ;
                            end else begin
                                state_q <= ST_PTR;
                                op_q    <= OP_PTR;
                            end
                        end else if (sw_go) begin
                            state_q <= ST_SW;
                            op_q    <= OP_SW;
                            req_q   <= 1'b1;
                        end
                    end
                    ST_PTR: begin
                        if (done) begin
                            if (err) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_READ;
                                op_q    <= OP_READ;
                                req_q   <= 1'b1;
                            end
                        end
                    end
                    ST_READ: if (done) state_q <= ST_IDLE;
                    ST_SW:   if (done) state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsense_poll_arb.sv
// Temperature poll arbiter top: schedules automatic sensor polls over the
// present slots, hands the engine to software only when polling is off and
// idle, and keeps one temperature register per slot.
// Assumes eng_err/eng_rdata are valid in the eng_done cycle.
module tsense_poll_arb
    import tsp_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int TEMP_W    = 16,
    parameter int RATE_W    = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        poll_en_cfg,
    input  logic                        thermal_lock,
    input  logic                        ptr_sel,
    input  logic [NUM_SLOTS-1:0]        slot_present,
    input  logic [RATE_W-1:0]           rate_limit,
    input  logic                        bus_err,
    input  logic                        soft_rst,
    input  logic                        sw_trig,
    input  logic                        eng_done,
    input  logic                        eng_err,
    input  logic [TEMP_W-1:0]           eng_rdata,
    output logic                        eng_req,
    output logic [1:0]                  eng_op,
    output logic [SLOT_W-1:0]           eng_slot,
    output logic                        busy,
    output logic                        poll_en_rd,
    output logic [SLOT_W-1:0]           last_slot,
    output logic [NUM_SLOTS*TEMP_W-1:0] temp_all
);
    logic              run, expired, start, sw_go, any_present, wr_en;
    logic [SLOT_W-1:0] pick;
    tsp_op_e           op;

    // The lock overrides software attempts to disable polling.
    assign poll_en_rd = poll_en_cfg | thermal_lock;
    assign run        = !busy && poll_en_rd && !soft_rst;
    assign start      = run && !bus_err && any_present && expired;
    assign sw_go      = sw_trig && !poll_en_rd;
    assign eng_op     = op;

    tsp_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .present (slot_present),
        .last    (last_slot),
        .pick    (pick),
        .any     (any_present)
    );

    tsp_interval #(.RATE_W(RATE_W)) u_ival (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .limit   (rate_limit),
        .expired (expired)
    );

    tsp_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .start    (start),
        .sw_go    (sw_go),
        .ptr_sel  (ptr_sel),
        .pick     (pick),
        .done     (eng_done),
        .err      (eng_err),
        .busy     (busy),
        .req      (eng_req),
        .op       (op),
        .slot     (eng_slot),
        .last     (last_slot),
        .wr_en    (wr_en)
    );

    // One temperature register per slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_temp
        logic [TEMP_W-1:0] temp_q;

        // Capture a successful read addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                temp_q <= '0;
            else if (wr_en && (eng_slot == SLOT_W'(g)))
                temp_q <= eng_rdata;
        end

        assign temp_all[g*TEMP_W +: TEMP_W] = temp_q;
    end
endmodule

// File: rtl/tsense_poll_arb_chk.sv
// Protocol checker for tsense_poll_arb, bound to every instance.
module tsense_poll_arb_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int TEMP_W    = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        soft_rst,
    input logic                        bus_err,
    input logic                        poll_en_rd,
    input logic [NUM_SLOTS-1:0]        slot_present,
    input logic                        eng_req,
    input logic [1:0]                  eng_op,
    input logic [SLOT_W-1:0]           eng_slot,
    input logic                        eng_done,
    input logic                        eng_err,
    input logic                        busy,
    input logic [SLOT_W-1:0]           last_slot,
    input logic [NUM_SLOTS*TEMP_W-1:0] temp_all
);
    localparam logic [1:0] OP_SW_C = 2'd2;

    // R3: software requests only follow a cycle with polling disabled
    a_r3_sw_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == OP_SW_C) |-> $past(!poll_en_rd));

    // R4: a transaction stays in flight until the engine reports done
    a_r4_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done && !soft_rst) |=> busy);

    // R5: no automatic request follows an idle cycle with a bus error
    a_r5_no_poll_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_err) |=> !(eng_req && eng_op != OP_SW_C));

    // R6: a poll start targets a slot that was present
    a_r6_present_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op != OP_SW_C && $past(!busy))
        |-> |($past(slot_present) & (NUM_SLOTS'(1) << eng_slot)));

    // R6: automatic requests carry the slot reported as last polled
    a_r6_slot_matches_last: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op != OP_SW_C) |-> (eng_slot == last_slot));

    // R9: temperatures only move after a clean done
    a_r9_temp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_done || eng_err) |=> $stable(temp_all));

    // R10: soft reset leaves the arbiter idle with no request
    a_r10_soft_rst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !eng_req));
endmodule

bind tsense_poll_arb tsense_poll_arb_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .TEMP_W    (TEMP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .bus_err      (bus_err),
    .poll_en_rd   (poll_en_rd),
    .slot_present (slot_present),
    .eng_req      (eng_req),
    .eng_op       (eng_op),
    .eng_slot     (eng_slot),
    .eng_done     (eng_done),
    .eng_err      (eng_err),
    .busy         (busy),
    .last_slot    (last_slot),
    .temp_all     (temp_all)
);

// File: tb/tsense_poll_arb_test.sv
module tsense_poll_arb_test;
    localparam int N  = 8;
    localparam int TW = 16;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          poll_en_cfg = 1'b0, thermal_lock = 1'b0, ptr_sel = 1'b0;
    logic [N-1:0]  slot_present = '0;
    logic [RW-1:0] rate_limit = 16'd3;
    logic          bus_err = 1'b0, soft_rst = 1'b0, sw_trig = 1'b0;
    logic          eng_done, eng_err;
    logic [TW-1:0] eng_rdata;
    logic          eng_req;
    logic [1:0]    eng_op;
    logic [2:0]    eng_slot, last_slot;
    logic          busy, poll_en_rd;
    logic [N*TW-1:0] temp_all;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;  // 125 MHz

    tsense_poll_arb #(.NUM_SLOTS(N), .TEMP_W(TW), .RATE_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .poll_en_cfg(poll_en_cfg), .thermal_lock(thermal_lock),
        .ptr_sel(ptr_sel), .slot_present(slot_present), .rate_limit(rate_limit),
        .bus_err(bus_err), .soft_rst(soft_rst), .sw_trig(sw_trig),
        .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_slot(eng_slot), .busy(busy),
        .poll_en_rd(poll_en_rd), .last_slot(last_slot), .temp_all(temp_all)
    );

    // Engine model: answers each request after 3 cycles and logs what it saw.
    logic        inj_err = 1'b0;
    int          cyc = 0, last_done = 0, last_gap = 0;
    int          n_rd = 0, n_ptr = 0, n_sw = 0;
    int          lat = 0;
    logic [7:0]  n_seq = '0;
    logic [1:0]  cur_op = '0;
    logic [2:0]  cur_slot = '0;
    logic [2:0]  rd_slot [256];
    logic [15:0] exp_temp [N];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            eng_done  <= 1'b0;
            eng_err   <= 1'b0;
            eng_rdata <= '0;
            lat       <= 0;
            for (int s = 0; s < N; s++) exp_temp[s] <= '0;
        end else begin
            eng_done <= 1'b0;
            if (eng_done) last_done <= cyc;
            if (eng_req) begin
                lat      <= 3;
                cur_op   <= eng_op;
                cur_slot <= eng_slot;
                case (eng_op)
                    2'd0: begin
                        rd_slot[n_rd[7:0]] <= eng_slot;
                        n_rd     <= n_rd + 1;
                        last_gap <= cyc - last_done;
                    end
                    2'd1:    n_ptr <= n_ptr + 1;
                    default: n_sw  <= n_sw + 1;
                endcase
            end else if (lat != 0) begin
                lat <= lat - 1;
                if (lat == 1) begin
                    eng_done  <= 1'b1;
                    eng_err   <= inj_err;
                    eng_rdata <= {4'h5, 1'b0, cur_slot, n_seq};
                    n_seq     <= n_seq + 1'b1;
                    if (cur_op == 2'd0 && !inj_err)
                        exp_temp[cur_slot] <= {4'h5, 1'b0, cur_slot, n_seq};
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_all();
        logic [127:0] v = '0;
        for (int s = 0; s < N; s++) v[s*16 +: 16] = exp_temp[s];
        return v;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    // Stimulus table: presence mask, pointer mode, expected next three slots.
    typedef struct packed {
        logic [7:0] mask;
        logic       ptr;
        logic [2:0] e0, e1, e2;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'hFF, 1'b0, 3'd0, 3'd1, 3'd2},
        '{8'hA4, 1'b1, 3'd5, 3'd7, 3'd2},
        '{8'h01, 1'b0, 3'd0, 3'd0, 3'd0},
        '{8'h88, 1'b1, 3'd3, 3'd7, 3'd3},
        '{8'h12, 1'b0, 3'd4, 3'd1, 3'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int br, bp, bs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 eng_req", eng_req, 0);
        chk("R1 last_slot", last_slot, 3'd7);
        chk("R1 temps", temp_all, 0);
        chk("R1 poll_en_rd", poll_en_rd, 0);

        // Table walk: R6 order, R7 phases, R9 stored readings
        rate_limit = 16'd3;
        for (int v = 0; v < 5; v++) begin
            slot_present = VEC[v].mask;
            ptr_sel      = VEC[v].ptr;
            br = n_rd;
            bp = n_ptr;
            poll_en_cfg = 1'b1;
            for (int i = 0; i < 3000 && n_rd < br + 3; i++) @(negedge clk);
            poll_en_cfg = 1'b0;
            wait_idle();
            chk($sformatf("R6 vec%0d slot0", v), rd_slot[br[7:0]], VEC[v].e0);
            chk($sformatf("R6 vec%0d slot1", v), rd_slot[8'(br + 1)], VEC[v].e1);
            chk($sformatf("R6 vec%0d slot2", v), rd_slot[8'(br + 2)], VEC[v].e2);
            chk($sformatf("R6 vec%0d last_slot", v), last_slot, VEC[v].e2);
            chk($sformatf("R7 vec%0d ptr writes", v), n_ptr - bp, VEC[v].ptr ? 0 : 3);
            chk($sformatf("R9 vec%0d temps", v), temp_all, exp_all());
        end

        // R2 lock forces polling; R3 trigger dropped while enabled
        thermal_lock = 1'b1;
        slot_present = 8'hFF;
        ptr_sel = 1'b1;
        @(negedge clk);
        chk("R2 lock readback", poll_en_rd, 1);
        br = n_rd;
        for (int i = 0; i < 500 && n_rd < br + 2; i++) @(negedge clk);
        chk("R2 polls under lock", n_rd >= br + 2, 1);
        bs = n_sw;
        pulse_sw();
        repeat (20) @(negedge clk);
        chk("R3 trigger ignored under lock", n_sw, bs);
        thermal_lock = 1'b0;
        @(negedge clk);
        chk("R2 readback after unlock", poll_en_rd, 0);
        wait_idle();

        // R3 trigger accepted when idle and disabled
        bs = n_sw;
        pulse_sw();
        wait_idle();
        chk("R3 software transaction", n_sw, bs + 1);

        // R4 disable mid-poll: poll completes, trigger dropped until done
        ptr_sel = 1'b0;
        rate_limit = 16'd2;
        bp = n_ptr; br = n_rd; bs = n_sw;
        poll_en_cfg = 1'b1;
        for (int i = 0; i < 500 && n_ptr == bp; i++) @(negedge clk);
        poll_en_cfg = 1'b0;
        pulse_sw();
        chk("R4 busy held after disable", busy, 1);
        wait_idle();
        chk("R4 read still issued", n_rd, br + 1);
        chk("R4 trigger during poll dropped", n_sw, bs);
        pulse_sw();
        wait_idle();
        chk("R4 trigger after handoff", n_sw, bs + 1);

        // R5 bus error holds polling off
        ptr_sel = 1'b1;
        bus_err = 1'b1;
        br = n_rd; bp = n_ptr;
        poll_en_cfg = 1'b1;
        repeat (60) @(negedge clk);
        chk("R5 no poll with error", n_rd + n_ptr, br + bp);
        bus_err = 1'b0;
        for (int i = 0; i < 50 && n_rd == br; i++) @(negedge clk);
        chk("R5 poll resumes", n_rd > br, 1);
        poll_en_cfg = 1'b0;
        wait_idle();

        // R9 read error keeps old value; R6 last slot still advances
        slot_present = 8'h20;
        inj_err = 1'b1;
        br = n_rd;
        poll_en_cfg = 1'b1;
        for (int i = 0; i < 500 && n_rd == br; i++) @(negedge clk);
        poll_en_cfg = 1'b0;
        wait_idle();
        inj_err = 1'b0;
        chk("R9 slot5 kept on error", temp_all[5*16 +: 16], exp_temp[5]);
        chk("R6 last_slot after error poll", last_slot, 3'd5);

        // R7 pointer-write error ends poll with no read
        ptr_sel = 1'b0;
        inj_err = 1'b1;
        bp = n_ptr; br = n_rd;
        poll_en_cfg = 1'b1;
        for (int i = 0; i < 500 && n_ptr == bp; i++) @(negedge clk);
        poll_en_cfg = 1'b0;
        wait_idle();
        inj_err = 1'b0;
        chk("R7 no read after pointer error", n_rd, br);

        // R8 poll interval
        ptr_sel = 1'b1;
        slot_present = 8'hFF;
        rate_limit = 16'd6;
        br = n_rd;
        poll_en_cfg = 1'b1;
        for (int i = 0; i < 500 && n_rd < br + 3; i++) @(negedge clk);
        poll_en_cfg = 1'b0;
        chk("R8 done-to-request gap", last_gap, 8);
        wait_idle();

        // R10 soft reset aborts a poll
        ptr_sel = 1'b0;
        rate_limit = 16'd1;
        bp = n_ptr; br = n_rd;
        poll_en_cfg = 1'b1;
        for (int i = 0; i < 500 && n_ptr == bp; i++) @(negedge clk);
        poll_en_cfg = 1'b0;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R10 busy cleared", busy, 0);
        chk("R10 no request", eng_req, 0);
        repeat (10) @(negedge clk);
        chk("R10 no read after abort", n_rd, br);
        chk("R10 temps untouched", temp_all, exp_all());

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule